// File: doc/BRIEF.md
# Receive DMA Buffer Chain Sequencer

This block is the per-channel control logic of a receive DMA engine. It accepts a byte stream with start-of-packet and end-of-packet markers from a receive FIFO and writes each accepted byte straight to host memory through an address/data strobe. The bytes go into a linked chain of host buffers. For every new buffer the block picks a small or a large size. It tracks the current buffer address, the current descriptor offset and the offset of the descriptor that opened the chain still waiting to be reported.

When a buffer closes, the next descriptor offset and the next buffer address are taken from next-pointer inputs that are valid on that same cycle. A buffer closes when its byte count reaches the selected size, or early when end-of-packet arrives. The chain is reported to a done queue in one of two ways. It can be reported after a programmable number of filled buffers. It can instead be reported only at end of packet. End of packet always reports the partial chain.

A buffer mode can place the first part of each packet in a small buffer and the rest of the packet in large ones. A transparent setting removes packet boundaries altogether. Illegal settings stop all transfer and raise an error flag.

Top module: `rx_chain_seq`

## Requirements
- R1: While `chan_en` is 0, `in_ready`, `mem_we` and `dq_we` are 0 and the tracked addresses, offsets and flags keep their values.
- R2: With `buf_mode` = 2'b00 every buffer closes after `large_size` bytes.
- R3: With `buf_mode` = 2'b01 every buffer closes after `small_size` bytes.
- R4: With `buf_mode` = 2'b10 the first buffer of each packet holds `small_size` bytes and later buffers of that packet hold `large_size` bytes. `first_buf` is 1 while the first buffer of a packet is being filled. It drops after that buffer closes mid-packet and returns to 1 after an accepted end-of-packet.
- R5: Each accepted byte (`in_valid` and `in_ready`) raises `mem_we` in the same cycle, with `mem_addr` = `cur_addr` and `mem_data` = `in_data`. If the byte does not close its buffer, `cur_addr` then advances by one.
- R6: On the byte that closes a buffer, `cur_addr` and `cur_desc` load `nxt_addr` and `nxt_desc`. The new values are visible from the next cycle.
- R7: With `thresh` = N (1 to 7), `dq_we` pulses on the byte that closes the Nth buffer since the last report, and `dq_ptr` equals `start_desc`. After every done-queue write, `start_desc` loads `nxt_desc` and the buffer count restarts.
- R8: With `thresh` = 0, `dq_we` pulses only on an accepted end-of-packet byte.
- R9: An accepted end-of-packet byte closes the buffer and always pulses `dq_we`, whatever the threshold. When the buffer also fills, or the threshold is also reached, on that byte, exactly one report is made.
- R10: With `transparent` = 1, `in_sop` and `in_eop` have no effect: buffers close only when full, and only the threshold triggers reports.
- R11: `buf_mode` = 2'b11, or `transparent` = 1 together with `thresh` = 0, drops `in_ready` in the same cycle. It sets `cfg_err` from the next cycle for as long as the setting stays illegal. `cfg_err` clears on the cycle after the settings are legal again.
- R12: After reset, `cur_addr`, `cur_desc` and `start_desc` are 0, `first_buf` is 1 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| buf_mode | input | 2 | 00 large only, 01 small only, 10 small first then large, 11 illegal |
| thresh | input | 3 | Buffers per report, 0 = report at end of packet only |
| transparent | input | 1 | No packet boundaries |
| small_size | input | 16 | Small buffer size in bytes |
| large_size | input | 16 | Large buffer size in bytes |
| in_valid | input | 1 | Byte present from receive FIFO |
| in_data | input | 8 | Byte value |
| in_sop | input | 1 | Byte starts a packet |
| in_eop | input | 1 | Byte ends a packet |
| in_ready | output | 1 | Byte is accepted this cycle |
| nxt_desc | input | 16 | Next descriptor offset, used when a buffer closes |
| nxt_addr | input | 32 | Next buffer address, used when a buffer closes |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 8 | Memory write data |
| dq_we | output | 1 | Done-queue write strobe |
| dq_ptr | output | 16 | Starting descriptor offset of the reported chain |
| cur_addr | output | 32 | Current buffer address |
| cur_desc | output | 16 | Current descriptor offset |
| start_desc | output | 16 | Starting descriptor offset of the open chain |
| first_buf | output | 1 | First buffer of a packet is being filled |
| cfg_err | output | 1 | Illegal configuration present |

## Verification
A buffer that fills and an end-of-packet can land on the same byte. The threshold count and an end-of-packet can also coincide. In each case the close logic and the report logic both act on one cycle. The bench provokes this with packets whose length equals the small buffer size, and with a mixed-size packet whose last partial buffer is also the threshold-th buffer. It judges the outcome by seeing exactly one `dq_we` pulse carrying the old `start_desc`, followed by a single reload of the descriptor and address state.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned PTR_W  = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned SIZE_W = 16;
    localparam int unsigned THR_W  = 3;

    typedef enum logic [1:0] {
        BM_LARGE = 2'b00,
        BM_SMALL = 2'b01,
        BM_MIXED = 2'b10,
        BM_BAD   = 2'b11
    } buf_mode_e;

    // accepted byte after transparent masking
    typedef struct packed {
        logic take;
        logic sop;
        logic eop;
    } byte_evt_t;

    // buffer close event handed to the report logic
    typedef struct packed {
        logic close;
        logic pkt_end;
    } close_evt_t;

    function automatic logic [SIZE_W-1:0] pick_size(
        input buf_mode_e         mode,
        input logic              first,
        input logic [SIZE_W-1:0] sm,
        input logic [SIZE_W-1:0] lg
    );
        case (mode)
            BM_SMALL: pick_size = sm;
            BM_MIXED: pick_size = first ? sm : lg;
            default:  pick_size = lg;
        endcase
    endfunction
endpackage

// File: rtl/rxc_cfg_guard.sv
module rxc_cfg_guard
    import rxc_pkg::*;
#(
    parameter int unsigned TW = THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  buf_mode_e     mode,
    input  logic [TW-1:0] thresh,
    input  logic          transparent,
    output logic          illegal,
    output logic          cfg_err
);
    always_comb begin
        illegal = (mode == BM_BAD) || (transparent && (thresh == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= illegal;
    end
endmodule

// File: rtl/rxc_buf_track.sv
module rxc_buf_track
    import rxc_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned PW = PTR_W,
    parameter int unsigned SW = SIZE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  byte_evt_t     evt,
    input  buf_mode_e     mode,
    input  logic [SW-1:0] small_size,
    input  logic [SW-1:0] large_size,
    input  logic [PW-1:0] nxt_desc,
    input  logic [AW-1:0] nxt_addr,
    output logic [AW-1:0] cur_addr,
    output logic [PW-1:0] cur_desc,
    output logic          first_buf,
    output close_evt_t    cev
);
    logic [SW-1:0] cnt_q;
    logic [SW-1:0] size_now;
    logic          first_eff;
    logic          full;

    always_comb begin
        first_eff   = first_buf | evt.sop;
        size_now    = pick_size(mode, first_eff, small_size, large_size);
        full        = (cnt_q + 1'b1) == size_now;
        cev.close   = evt.take & (full | evt.eop);
        cev.pkt_end = evt.take & evt.eop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            cur_addr  <= '0;
            cur_desc  <= '0;
            first_buf <= 1'b1;
        end else if (evt.take) begin
            if (cev.close) begin
                cnt_q     <= '0;
                cur_addr  <= nxt_addr;
                cur_desc  <= nxt_desc;
                first_buf <= evt.eop;
            end else begin
                cnt_q     <= cnt_q + 1'b1;
                cur_addr  <= cur_addr + 1'b1;
                first_buf <= first_eff;
            end
        end
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.take && !cev.close) |=> cur_addr == $past(cur_addr) + 1'b1);

    // R4
    first_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        cev.pkt_end |=> first_buf);
endmodule

// File: rtl/rxc_done_ctl.sv
module rxc_done_ctl
    import rxc_pkg::*;
#(
    parameter int unsigned PW = PTR_W,
    parameter int unsigned TW = THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  close_evt_t    cev,
    input  logic [TW-1:0] thresh,
    input  logic [PW-1:0] nxt_desc,
    output logic          dq_we,
    output logic [PW-1:0] dq_ptr,
    output logic [PW-1:0] start_desc
);
    logic [TW-1:0] nfill_q;
    logic          hit;

    always_comb begin
        hit    = (thresh != '0) && ((nfill_q + 1'b1) == thresh);
        dq_we  = cev.close & (cev.pkt_end | hit);
        dq_ptr = start_desc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nfill_q    <= '0;
            start_desc <= '0;
        end else if (dq_we) begin
            nfill_q    <= '0;
            start_desc <= nxt_desc;
        end else if (cev.close) begin
            nfill_q    <= nfill_q + 1'b1;
        end
    end

    // R8
    thr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0 && cev.close && !cev.pkt_end) |-> !dq_we);
endmodule

// File: rtl/rx_chain_seq.sv
module rx_chain_seq
    import rxc_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned PW = PTR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned SW = SIZE_W,
    parameter int unsigned TW = THR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic [1:0]    buf_mode,
    input  logic [TW-1:0] thresh,
    input  logic          transparent,
    input  logic [SW-1:0] small_size,
    input  logic [SW-1:0] large_size,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_sop,
    input  logic          in_eop,
    output logic          in_ready,
    input  logic [PW-1:0] nxt_desc,
    input  logic [AW-1:0] nxt_addr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    output logic          dq_we,
    output logic [PW-1:0] dq_ptr,
    output logic [AW-1:0] cur_addr,
    output logic [PW-1:0] cur_desc,
    output logic [PW-1:0] start_desc,
    output logic          first_buf,
    output logic          cfg_err
);
    buf_mode_e  mode;
    logic       illegal;
    byte_evt_t  evt;
    close_evt_t cev;

    assign mode = buf_mode_e'(buf_mode);

    rxc_cfg_guard #(.TW(TW)) u_guard (
        .clk(clk), .rst(rst), .mode(mode), .thresh(thresh),
        .transparent(transparent), .illegal(illegal), .cfg_err(cfg_err)
    );

    always_comb begin
        in_ready = chan_en & ~illegal & ~cfg_err;
        evt.take = in_valid & in_ready;
        evt.sop  = in_sop & ~transparent;
        evt.eop  = in_eop & ~transparent;
        mem_we   = evt.take;
        mem_addr = cur_addr;
        mem_data = in_data;
    end

    rxc_buf_track #(.AW(AW), .PW(PW), .SW(SW)) u_track (
        .clk(clk), .rst(rst), .evt(evt), .mode(mode),
        .small_size(small_size), .large_size(large_size),
        .nxt_desc(nxt_desc), .nxt_addr(nxt_addr),
        .cur_addr(cur_addr), .cur_desc(cur_desc),
        .first_buf(first_buf), .cev(cev)
    );

    rxc_done_ctl #(.PW(PW), .TW(TW)) u_done (
        .clk(clk), .rst(rst), .cev(cev), .thresh(thresh),
        .nxt_desc(nxt_desc), .dq_we(dq_we), .dq_ptr(dq_ptr),
        .start_desc(start_desc)
    );

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |-> (!mem_we && !dq_we));

    // R11
    bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_mode == 2'b11 || cfg_err) |-> !in_ready);

    // R9
    pkt_end_dq_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_eop && !transparent) |-> dq_we);
endmodule

// File: tb/sim_rx_chain_seq.sv
module sim_rx_chain_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic [1:0]  buf_mode = 2'b00;
    logic [2:0]  thresh = 3'd0;
    logic        transparent = 1'b0;
    logic [15:0] small_size = 16'd3;
    logic [15:0] large_size = 16'd5;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [15:0] nxt_desc = 16'h0;
    logic [31:0] nxt_addr = 32'h0;
    logic        in_ready, mem_we, dq_we, first_buf, cfg_err;
    logic [31:0] mem_addr, cur_addr;
    logic [7:0]  mem_data;
    logic [15:0] dq_ptr, cur_desc, start_desc;

    int n_chk = 0;
    int n_err = 0;
    int nstep = 0;
    logic [31:0] m_addr;
    logic [15:0] m_desc, m_start;
    logic        m_first;
    int          m_cnt, m_nf;

    always #4 clk = ~clk;

    rx_chain_seq u0 (
        .clk(clk), .rst(rst), .chan_en(chan_en), .buf_mode(buf_mode),
        .thresh(thresh), .transparent(transparent),
        .small_size(small_size), .large_size(large_size),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_ready(in_ready), .nxt_desc(nxt_desc),
        .nxt_addr(nxt_addr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .dq_we(dq_we), .dq_ptr(dq_ptr),
        .cur_addr(cur_addr), .cur_desc(cur_desc), .start_desc(start_desc),
        .first_buf(first_buf), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " cur_addr"}, cur_addr, m_addr);
        check({tag, " cur_desc"}, {16'h0, cur_desc}, {16'h0, m_desc});
        check({tag, " start_desc"}, {16'h0, start_desc}, {16'h0, m_start});
        check({tag, " first_buf"}, {31'h0, first_buf}, {31'h0, m_first});
    endtask

    // one accepted byte, checked against the requirement model
    task automatic push(input string tag, input logic [7:0] d, input logic s, input logic e);
        logic [15:0] sz;
        logic fe, ee, se, cl, dq;
        nstep++;
        @(negedge clk);
        nxt_desc = 16'h0100 + 16'(nstep);
        nxt_addr = 32'h2000_0000 + (32'(nstep) << 8);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        ee = e & ~transparent;
        se = s & ~transparent;
        fe = m_first | se;
        sz = (buf_mode == 2'b00) ? large_size :
             (buf_mode == 2'b01) ? small_size : (fe ? small_size : large_size);
        cl = (32'(m_cnt) + 1 == 32'(sz)) | ee;
        dq = cl & (ee | (thresh != 3'd0 && m_nf + 1 == int'(thresh)));
        #1;
        check({tag, " R5 in_ready"}, {31'h0, in_ready}, 32'h1);
        check({tag, " R5 mem_we"}, {31'h0, mem_we}, 32'h1);
        check({tag, " R5 mem_addr"}, mem_addr, m_addr);
        check({tag, " R5 mem_data"}, {24'h0, mem_data}, {24'h0, d});
        check({tag, " R7 dq_we"}, {31'h0, dq_we}, {31'h0, dq});
        if (dq) check({tag, " R7 dq_ptr"}, {16'h0, dq_ptr}, {16'h0, m_start});
        if (cl) begin
            m_cnt = 0; m_addr = nxt_addr; m_desc = nxt_desc; m_first = ee;
        end else begin
            m_cnt++; m_addr = m_addr + 1; m_first = fe;
        end
        if (dq) begin
            m_nf = 0; m_start = nxt_desc;
        end else if (cl) begin
            m_nf++;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        check_state({tag, " R6"});
    endtask

    task automatic send_pkt(input string tag, input int len);
        for (int i = 0; i < len; i++)
            push(tag, 8'(8'hA0 + i), i == 0, i == len - 1);
    endtask

    task automatic t_reset();
        m_addr = 0; m_desc = 0; m_start = 0; m_first = 1'b1; m_cnt = 0; m_nf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check_state("R12 reset");
        check("R12 cfg_err", {31'h0, cfg_err}, 32'h0);
        check("R1 in_ready off", {31'h0, in_ready}, 32'h0);
    endtask

    task automatic t_disabled();
        @(negedge clk);
        chan_en = 1'b0; in_valid = 1'b1; in_eop = 1'b1; in_data = 8'h55;
        #1;
        check("R1 in_ready", {31'h0, in_ready}, 32'h0);
        check("R1 mem_we", {31'h0, mem_we}, 32'h0);
        check("R1 dq_we", {31'h0, dq_we}, 32'h0);
        @(posedge clk); #1;
        check_state("R1 hold");
        in_valid = 1'b0; in_eop = 1'b0; chan_en = 1'b1;
    endtask

    task automatic t_large();
        buf_mode = 2'b00; thresh = 3'd0;
        send_pkt("R2 R8 large", 12);
    endtask

    task automatic t_small();
        buf_mode = 2'b01; thresh = 3'd2;
        send_pkt("R3 R7 small", 7);
    endtask

    task automatic t_mixed();
        buf_mode = 2'b10; thresh = 3'd3;
        send_pkt("R4 R9 mixed", 10);
        send_pkt("R9 full+eop", 3);
        buf_mode = 2'b10; thresh = 3'd0;
        push("R4 first", 8'h11, 1'b1, 1'b0);
        check("R4 first_buf held", {31'h0, first_buf}, 32'h1);
        push("R4 first", 8'h12, 1'b0, 1'b0);
        push("R4 first", 8'h13, 1'b0, 1'b0);
        check("R4 first_buf dropped", {31'h0, first_buf}, 32'h0);
        push("R4 first", 8'h14, 1'b0, 1'b1);
        check("R4 first_buf rearmed", {31'h0, first_buf}, 32'h1);
    endtask

    task automatic t_eop_force();
        buf_mode = 2'b00; thresh = 3'd7;
        send_pkt("R9 short", 2);
    endtask

    task automatic t_transparent();
        transparent = 1'b1; buf_mode = 2'b10; thresh = 3'd1;
        for (int i = 0; i < 8; i++)
            push("R10 transparent", 8'(i), 1'b1, 1'b1);
        transparent = 1'b0;
        buf_mode = 2'b00; thresh = 3'd0;
    endtask

    task automatic t_illegal();
        @(negedge clk);
        buf_mode = 2'b11; in_valid = 1'b1;
        #1;
        check("R11 ready drop", {31'h0, in_ready}, 32'h0);
        check("R11 no write", {31'h0, mem_we}, 32'h0);
        @(posedge clk); #1;
        check("R11 cfg_err set", {31'h0, cfg_err}, 32'h1);
        @(posedge clk); #1;
        check("R11 cfg_err held", {31'h0, cfg_err}, 32'h1);
        check_state("R11 hold");
        @(negedge clk); in_valid = 1'b0; buf_mode = 2'b01;
        @(posedge clk); #1;
        check("R11 cfg_err clear", {31'h0, cfg_err}, 32'h0);
        check("R11 ready back", {31'h0, in_ready}, 32'h1);
        @(negedge clk); transparent = 1'b1; thresh = 3'd0;
        #1;
        check("R10 R11 transp thr0", {31'h0, in_ready}, 32'h0);
        @(posedge clk); #1;
        check("R10 R11 cfg_err", {31'h0, cfg_err}, 32'h1);
        @(negedge clk); thresh = 3'd2;
        @(posedge clk); #1;
        check("R11 recovered", {31'h0, cfg_err}, 32'h0);
        transparent = 1'b0;
    endtask

    initial begin
        t_reset();
        chan_en = 1'b1;
        t_disabled();
        t_large();
        t_small();
        t_mixed();
        t_eop_force();
        t_transparent();
        t_illegal();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule